// File: doc/BRIEF.md
# SPI Chip-Select Delay Timer

This timer produces the programmable waits that frame a chip-select cycle in an SPI master. It covers two waits. One is the hold from the final serial-clock edge of a frame to chip-select release. The other is the idle gap from chip-select release to the next assertion. A controller sets the delay codes and the mode, then pulses `start`. The timer counts system clocks and raises `done` for one cycle when the wait is over.

The programmed length is an odd prescaler times a power-of-two scaler, in system clocks, with no constant added. For the inter-frame gap the length also depends on the clocking mode. With a free-running serial clock the gap is either pinned to one serial-clock period, or it is the programmed length stretched until the next active serial-clock edge. That edge arrives as a one-cycle strobe on `sck_edge`.

Top module: `csdly_timer`

## Requirements
- R1: A synchronous active-high `rst` clears all state. While it is applied and just after it is released, `busy` and `done` are 0. A delay cut short by `rst` never produces `done`.
- R2: Prescaler code p (2 bits) selects the value 2p+1, so 00→1, 01→3, 10→5 and 11→7. Scaler code s (4 bits) selects 2^(s+1). The programmed length N is their product. If `start` is accepted at clock edge k, `done` is high in the cycle after edge k+N.
- R3: Prescaler code 01 with scaler code 1110 gives a delay of 98304 clocks.
- R4: With `gap_sel`=1 and `cont_clk`=0, the gap is the programmed N, whatever `edge_align` is.
- R5: With `gap_sel`=1, `cont_clk`=1 and `edge_align`=0, the gap is SCK_DIV clocks (4 by default), whatever the codes are.
- R6: With `gap_sel`=1, `cont_clk`=1 and `edge_align`=1, `done` comes at the first edge at or after k+N at which `sck_edge` is sampled high. If the strobe falls on edge k+N itself, `done` comes at k+N.
- R7: With `gap_sel`=0 (the post-clock hold), the delay is always the programmed N, whatever `cont_clk` and `edge_align` are.
- R8: `done` is high for exactly one cycle. `busy` is high from the accepting edge until the edge that raises `done`, and is low while `done` is high.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the running delay nor any later output.
- R10: The codes and mode inputs are sampled only on the accepting edge. Changing them during a delay has no effect on that delay.
- R11: `sck_edge` has no effect unless `gap_sel`, `cont_clk` and `edge_align` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a delay, taken when idle |
| presc_code | input | 2 | Odd prescaler select |
| scale_code | input | 4 | Power-of-two scaler select |
| gap_sel | input | 1 | 1: inter-frame gap, 0: post-clock hold |
| cont_clk | input | 1 | Serial clock free-running |
| edge_align | input | 1 | Stretch the gap to the next serial-clock edge |
| sck_edge | input | 1 | One-cycle strobe marking an active serial-clock edge |
| busy | output | 1 | A delay is in progress |
| done | output | 1 | One-cycle pulse at the end of the delay |

## Verification
Two events can land in the same cycle: the count running out and a serial-clock strobe arriving. The bench provokes this by holding back `start` until the strobe phase is known, so that edge k+N falls exactly on a strobe. `done` must then appear at k+N and not one serial period later. In the neighbouring cases the count ends one or more clocks before a strobe, and `done` must wait for that strobe. The expected edge is found from the known strobe schedule.

// File: rtl/csdly_pkg.sv
`timescale 1ns/1ps
package csdly_pkg;

    localparam int PRE_W = 2;
    localparam int SCL_W = 4;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [SCL_W-1:0] scale;
        logic             gap;
        logic             cont;
        logic             align;
    } dly_cfg_t;

    typedef enum logic [1:0] {
        MD_PROG,
        MD_ONE_SCK,
        MD_PROG_ALIGN
    } dly_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT
    } dly_state_e;

    // odd prescaler value 2*code+1
    function automatic logic [PRE_W:0] presc_value(input logic [PRE_W-1:0] code);
        return {code, 1'b1};
    endfunction

    // alignment and the fixed period only ever apply to the inter-frame gap
    function automatic dly_mode_e pick_mode(input dly_cfg_t c);
        if (!c.gap || !c.cont)
            return MD_PROG;
        else if (c.align)
            return MD_PROG_ALIGN;
        else
            return MD_ONE_SCK;
    endfunction

endpackage

// File: rtl/csdly_len.sv
`timescale 1ns/1ps
module csdly_len
    import csdly_pkg::*;
#(
    parameter int CNT_W   = 19,
    parameter int SCK_DIV = 4
) (
    input  dly_cfg_t         cfg,
    output logic [CNT_W-1:0] len,
    output dly_mode_e        mode
);

    localparam int PV_W = PRE_W + 1;
    localparam int SH_W = SCL_W + 1;

    logic [CNT_W-1:0] pv_ext;
    logic [SH_W-1:0]  shamt;
    logic [CNT_W-1:0] prog_len;

    always_comb begin
        pv_ext            = '0;
        pv_ext[PV_W-1:0]  = presc_value(cfg.presc);
        shamt             = {1'b0, cfg.scale} + SH_W'(1);
        prog_len          = pv_ext << shamt;
    end

    always_comb begin
        mode = pick_mode(cfg);
        if (mode == MD_ONE_SCK)
            len = CNT_W'(SCK_DIV);
        else
            len = prog_len;
    end

endmodule

// File: rtl/csdly_count.sv
`timescale 1ns/1ps
module csdly_count #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CNT_W'(1));

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> load_val != '0) else $error("zero-length load"); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt != '0) else $error("counter ran past zero"); // R2
    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> !run) else $error("reload during a running delay"); // R9

endmodule

// File: rtl/csdly_ctrl.sv
`timescale 1ns/1ps
module csdly_ctrl
    import csdly_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  dly_mode_e mode_in,
    input  logic      last,
    input  logic      sck_edge,
    output logic      load,
    output logic      run,
    output logic      busy,
    output logic      done
);

    dly_state_e state;
    dly_mode_e  mode_q;
    logic       finish;

    assign load = start && (state == ST_IDLE);
    assign run  = (state == ST_RUN);
    assign busy = (state != ST_IDLE);

    always_comb begin
        finish = 1'b0;
        if (state == ST_RUN && last)
            finish = (mode_q != MD_PROG_ALIGN) || sck_edge;
        else if (state == ST_WAIT)
            finish = sck_edge;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_q <= MD_PROG;
            done   <= 1'b0;
        end else begin
            done <= finish;
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_RUN;
                    mode_q <= mode_in;
                end
                ST_RUN:  if (last) state <= finish ? ST_IDLE : ST_WAIT;
                ST_WAIT: if (sck_edge) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("busy while done"); // R8
    AST_ALIGN_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == MD_PROG_ALIGN) |-> $past(sck_edge)) else $error("aligned done off edge"); // R6
    AST_WAIT_ALIGN_ONLY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> (mode_q == MD_PROG_ALIGN)) else $error("edge wait outside align mode"); // R11
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mode_q)) else $error("mode changed by start while busy"); // R9

endmodule

// File: rtl/csdly_timer.sv
`timescale 1ns/1ps
module csdly_timer
    import csdly_pkg::*;
#(
    parameter int CNT_W   = 19,
    parameter int SCK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PRE_W-1:0] presc_code,
    input  logic [SCL_W-1:0] scale_code,
    input  logic             gap_sel,
    input  logic             cont_clk,
    input  logic             edge_align,
    input  logic             sck_edge,
    output logic             busy,
    output logic             done
);

    dly_cfg_t         cfg;
    dly_mode_e        mode;
    logic [CNT_W-1:0] len;
    logic             load;
    logic             run;
    logic             last;

    always_comb begin
        cfg.presc = presc_code;
        cfg.scale = scale_code;
        cfg.gap   = gap_sel;
        cfg.cont  = cont_clk;
        cfg.align = edge_align;
    end

    csdly_len #(.CNT_W(CNT_W), .SCK_DIV(SCK_DIV)) u_len (
        .cfg  (cfg),
        .len  (len),
        .mode (mode)
    );

    csdly_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (len),
        .run      (run),
        .last     (last)
    );

    csdly_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode_in  (mode),
        .last     (last),
        .sck_edge (sck_edge),
        .load     (load),
        .run      (run),
        .busy     (busy),
        .done     (done)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!busy && !done)) else $error("outputs active after reset"); // R1

endmodule

// File: tb/csdly_timer_bench.sv
`timescale 1ns/1ps
module csdly_timer_bench;

    typedef struct packed {
        logic [1:0] p;
        logic [3:0] s;
        logic       g;
        logic       c;
        logic       a;
        int         exp;
        int         req;
    } vec_t;

    // R4 R2 R7 R5 R11 rows; sck strobe runs throughout
    localparam vec_t TBL [10] = '{
        '{2'b00, 4'b0000, 1'b1, 1'b0, 1'b0,   2, 4},   // R4
        '{2'b01, 4'b0000, 1'b1, 1'b0, 1'b0,   6, 2},   // R2
        '{2'b10, 4'b0001, 1'b1, 1'b0, 1'b0,  20, 2},   // R2
        '{2'b11, 4'b0010, 1'b0, 1'b0, 1'b0,  56, 7},   // R7
        '{2'b11, 4'b0011, 1'b1, 1'b1, 1'b0,   4, 5},   // R5
        '{2'b00, 4'b0000, 1'b1, 1'b1, 1'b0,   4, 5},   // R5
        '{2'b01, 4'b0001, 1'b0, 1'b1, 1'b1,  12, 7},   // R7
        '{2'b10, 4'b0000, 1'b1, 1'b0, 1'b1,  10, 11},  // R11
        '{2'b11, 4'b0100, 1'b1, 1'b0, 1'b0, 224, 4},   // R4
        '{2'b00, 4'b1000, 1'b1, 1'b0, 1'b0, 512, 2}    // R2
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] presc = 2'b00;
    logic [3:0] scale = 4'b0000;
    logic       gap = 1'b0;
    logic       cont = 1'b0;
    logic       align = 1'b0;
    logic       sck_edge = 1'b0;
    logic       busy;
    logic       done;

    int ecnt  = 0;
    int total = 0;
    int bad   = 0;

    csdly_timer u_csdly_timer (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .presc_code (presc),
        .scale_code (scale),
        .gap_sel    (gap),
        .cont_clk   (cont),
        .edge_align (align),
        .sck_edge   (sck_edge),
        .busy       (busy),
        .done       (done)
    );

    initial forever #2.5 clk = ~clk;

    initial forever begin
        @(posedge clk);
        ecnt++;
    end

    // strobe high at every edge whose index is a multiple of 4
    initial forever begin
        @(negedge clk);
        sck_edge = ((ecnt + 1) % 4 == 0);
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all-reqs: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_align(input int ks, input int n);
        int e = ks + n;
        while (e % 4 != 0) e++;
        return e - ks;
    endfunction

    task automatic run_delay(input logic [1:0] p, input logic [3:0] s,
                             input logic g, input logic c, input logic a,
                             input int ph, input int lim,
                             output int cyc, output int ks);
        if (ph >= 0) begin
            do @(negedge clk); while (((ecnt + 1) % 4) != ph);
        end else begin
            @(negedge clk);
        end
        presc = p; scale = s; gap = g; cont = c; align = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ks  = ecnt;
        cyc = 0;
        while (!done && cyc < lim) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        int cyc;
        int ks;
        int n;

        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "reset outputs", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "after release", {busy, done}, 0);

        for (int i = 0; i < 10; i++) begin
            run_delay(TBL[i].p, TBL[i].s, TBL[i].g, TBL[i].c, TBL[i].a, -1,
                      TBL[i].exp + 40, cyc, ks);
            chk(cyc == TBL[i].exp, $sformatf("R%0d", TBL[i].req),
                $sformatf("table row %0d", i), cyc, TBL[i].exp);
        end

        // R8: pulse width and busy after done
        run_delay(2'b01, 4'b0001, 1'b1, 1'b0, 1'b0, -1, 60, cyc, ks);
        chk(busy == 1'b0, "R8", "busy during done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done width", done, 0);
        run_delay(2'b00, 4'b0010, 1'b1, 1'b0, 1'b0, -1, 60, cyc, ks);
        chk(cyc == 8, "R8", "back-to-back start", cyc, 8);

        // R3
        run_delay(2'b01, 4'b1110, 1'b1, 1'b0, 1'b0, -1, 100000, cyc, ks);
        chk(cyc == 98304, "R3", "long delay", cyc, 98304);

        // R6: expiry on a strobe edge
        run_delay(2'b00, 4'b0001, 1'b1, 1'b1, 1'b1, 0, 60, cyc, ks);
        chk(cyc == 4, "R6", "expiry meets strobe", cyc, 4);
        // R6: held to next strobe
        run_delay(2'b00, 4'b0000, 1'b1, 1'b1, 1'b1, 0, 60, cyc, ks);
        chk(cyc == 4, "R6", "hold 2 to strobe", cyc, 4);
        run_delay(2'b01, 4'b0000, 1'b1, 1'b1, 1'b1, 1, 60, cyc, ks);
        chk(cyc == 7, "R6", "hold 6 to strobe", cyc, 7);
        run_delay(2'b11, 4'b0010, 1'b1, 1'b1, 1'b1, 2, 120, cyc, ks);
        chk(cyc == exp_align(ks, 56), "R6", "hold 56 to strobe", cyc, exp_align(ks, 56));

        // R9: start while busy is ignored
        @(negedge clk);
        presc = 2'b10; scale = 4'b0001; gap = 1'b1; cont = 1'b0; align = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        repeat (4) begin @(negedge clk); cyc++; end
        presc = 2'b11; scale = 4'b0100; start = 1'b1;
        @(negedge clk);
        cyc++;
        start = 1'b0;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        chk(cyc == 20, "R9", "busy start ignored", cyc, 20);
        n = 0;
        repeat (300) begin @(negedge clk); if (done) n++; end
        chk(n == 0, "R9", "no queued delay", n, 0);

        // R10: inputs changed mid-delay
        @(negedge clk);
        presc = 2'b11; scale = 4'b0010; gap = 1'b0; cont = 1'b0; align = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        repeat (3) begin @(negedge clk); cyc++; end
        presc = 2'b00; scale = 4'b1111; gap = 1'b1; cont = 1'b1; align = 1'b1;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        chk(cyc == 56, "R10", "codes frozen", cyc, 56);

        // R1: reset during a delay
        @(negedge clk);
        presc = 2'b11; scale = 4'b0100; gap = 1'b1; cont = 1'b0; align = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy == 1'b0, "R1", "busy after mid reset", busy, 0);
        n = 0;
        repeat (300) begin @(negedge clk); if (done) n++; end
        chk(n == 0, "R1", "no done after reset", n, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule